// File: doc/BRIEF.md
# Programmable-Count Serial Bus Shifter

This block is the transmit engine of a two-wire serial bus master. For each accepted byte it generates a serial clock on an open-drain SCL line and shifts a programmable number of data bits out on SDA, most significant bit first. One extra clock pulse can follow the data bits as an acknowledge slot. During that slot the block releases SDA, samples the line and keeps the sampled value as a status bit. A one-cycle done pulse marks the end of every transfer. Start and stop conditions, arbitration, slave operation and fast-mode timing are handled elsewhere.

An 8-bit configuration register sets three things: the data bit count, the acknowledge mode and the serial clock rate. The rate follows a divide-by-(2^n + 36) law, with n chosen by a 3-bit code. The register's lowest bit is shared. A write sets the lowest clock-select bit, but a read returns a monitor of the bus-enable state. A read-modify-write of this register therefore corrupts that bit. Pulling `bus_en` low puts the engine into a software reset: any running transfer is aborted and both lines are released.

The transmit byte arrives on a valid/ready interface. A transfer starts on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is high only while the engine is idle and enabled, so back-pressure lasts for the whole transfer. The source must hold `tx_valid` and `tx_data` stable until it sees the handshake. The configuration is captured at the handshake.

Top module: `sbus_shifter`

## Requirements
- R1: After reset the count field, acknowledge-mode bit and clock-select field are all 0. The read layout is: bit 7 = 0, bits [6:4] = bit-count code, bit 3 = acknowledge mode, bits [2:1] = upper clock-select bits, bit 0 = monitor.
- R2: Read bit 0 always equals `bus_en`, whatever value was written there. The written value of bit 0 still acts as clock-select bit 0.
- R3: The number of data clock pulses is 8 for count code 0 and k for code k (1 to 7). The data bits are `tx_data[7]` downward, one per SCL rising edge.
- R4: With acknowledge mode 1, one more SCL pulse follows the data bits. SDA is released for that pulse, and the line value in the first high cycle is latched into `ack_seen`. With acknowledge mode 0 there is no extra pulse and `ack_seen` keeps its previous value.
- R5: Every SCL low phase and every SCL high phase lasts H = (2^n + 36)/2 system clocks. n = code + 4 for clock-select codes 0 to 6, and reserved code 7 behaves as code 6.
- R6: `sda_oe` changes only while SCL is low; it never changes between two consecutive cycles in which SCL is high.
- R7: For a transfer of N pulses, `done` is high for exactly one cycle: cycle 2·H·N + 1 after the accepting clock edge. SCL is then high and SDA keeps its last value.
- R8: `tx_ready` is high only when the engine is enabled and idle. SCL falls in the first cycle after the accepting edge, and `tx_ready` stays low until the done cycle.
- R9: While `bus_en` is low, `scl_oe`, `sda_oe` and `tx_ready` are 0, a running transfer is aborted and no `done` is produced.
- R10: Register writes during a transfer do not change the pulse count, acknowledge mode or phase length of that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus enable; low holds the engine in software reset |
| reg_we | input | 1 | Configuration register write strobe |
| reg_wdata | input | 8 | Configuration write data |
| reg_rdata | output | 8 | Configuration read data, with the monitor in bit 0 |
| tx_valid | input | 1 | Transmit byte valid |
| tx_ready | output | 1 | Engine idle and enabled; accepts the byte |
| tx_data | input | 8 | Transmit byte, MSB sent first |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| done | output | 1 | One-cycle end-of-transfer pulse |
| ack_seen | output | 1 | SDA level sampled in the acknowledge slot |

## Verification
`tx_ready`, `reg_rdata` and the line enables follow `bus_en` in the same cycle. SCL falls in the first cycle after the accepting edge. Each phase then lasts exactly H cycles, and `done` arrives in cycle 2·H·N + 1 and is gone one cycle later. The bench sets the handshake one falling edge before a rising edge and samples every output at the falling edges. It counts cycles from the accepting edge and tests each phase length and the done cycle against that arithmetic. `ack_seen` is checked in the cycle after `done`, and data and acknowledge bits are captured in the first high cycle of each pulse.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int CNT_W = 3;
  localparam int SEL_W = 3;
  localparam int REG_W = 8;

  typedef struct packed {
    logic [CNT_W-1:0] nbits;
    logic             ack_en;
    logic [SEL_W-1:0] clksel;
  } sbus_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } sbus_state_e;
endpackage

// File: rtl/sbus_cfg_reg.sv
module sbus_cfg_reg
  import sbus_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  input  logic             mon,
  output sbus_cfg_t        cfg,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      cfg.nbits  <= wdata[6:4];
      cfg.ack_en <= wdata[3];
      cfg.clksel <= wdata[2:0];
    end
  end

  // bit 0 is write-only clock select; reads return the monitor instead
  assign rdata = {1'b0, cfg.nbits, cfg.ack_en, cfg.clksel[2:1], mon};
endmodule

// File: rtl/sbus_half_sel.sv
module sbus_half_sel
  import sbus_pkg::*;
#(
  parameter int N_BASE     = 4,
  parameter int DIV_OFFSET = 36,
  parameter int HALF_W     = 10
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [HALF_W-1:0] half
);
  localparam int CODES    = 1 << SEL_W;
  localparam int TOP_CODE = CODES - 2;

  logic [HALF_W-1:0] lut [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_code
    localparam int EFF_N = N_BASE + ((g > TOP_CODE) ? TOP_CODE : g);
    localparam int HVAL  = ((1 << EFF_N) + DIV_OFFSET) / 2;
    assign lut[g] = HALF_W'(HVAL);
  end

  assign half = lut[sel];
endmodule

// File: rtl/sbus_phase_timer.sv
module sbus_phase_timer #(
  parameter int HALF_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              first,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;

  assign first = run && (cnt == '0);
  assign tick  = run && (cnt == half - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/sbus_shift_core.sv
module sbus_shift_core
  import sbus_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int HALF_W  = 10,
  parameter int PULSE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  sbus_cfg_t         cfg,
  input  logic [HALF_W-1:0] half_in,
  input  logic              sda_in,
  input  logic              first,
  input  logic              tick,
  output logic              tx_ready,
  output logic              run,
  output logic [HALF_W-1:0] half_q,
  output logic              scl_q,
  output logic              sda_q,
  output logic              done,
  output logic              ack_seen
);
  sbus_state_e        state;
  logic [DATA_W-1:0]  shreg;
  logic [PULSE_W-1:0] pidx, ndata_q, nlast_q;
  logic               ack_q;
  logic [PULSE_W-1:0] ndata_w;
  logic               accept, in_ack, is_last;

  assign ndata_w  = (cfg.nbits == '0) ? PULSE_W'(DATA_W) : PULSE_W'(cfg.nbits);
  assign tx_ready = en && (state == ST_IDLE);
  assign accept   = tx_ready && tx_valid;
  assign run      = (state != ST_IDLE);
  assign in_ack   = ack_q && (pidx == ndata_q);
  assign is_last  = (pidx == nlast_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      pidx     <= '0;
      ndata_q  <= '0;
      nlast_q  <= '0;
      ack_q    <= 1'b0;
      half_q   <= '0;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      done     <= 1'b0;
      ack_seen <= 1'b0;
    end else if (!en) begin
      state <= ST_IDLE;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            shreg   <= tx_data;
            pidx    <= '0;
            ndata_q <= ndata_w;
            nlast_q <= ndata_w + PULSE_W'(cfg.ack_en) - PULSE_W'(1);
            ack_q   <= cfg.ack_en;
            half_q  <= half_in;
            scl_q   <= 1'b0;
            state   <= ST_LOW;
          end
        end
        ST_LOW: begin
          if (first) begin
            if (in_ack) begin
              sda_q <= 1'b1;
            end else begin
              sda_q <= shreg[DATA_W-1];
              shreg <= {shreg[DATA_W-2:0], 1'b0};
            end
          end
          if (tick) begin
            scl_q <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (first && in_ack) ack_seen <= sda_in;
          if (tick) begin
            if (is_last) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              pidx  <= pidx + PULSE_W'(1);
              scl_q <= 1'b0;
              state <= ST_LOW;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbus_shifter.sv
module sbus_shifter
  import sbus_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int N_BASE     = 4,
  parameter int DIV_OFFSET = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_en,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              done,
  output logic              ack_seen
);
  localparam int N_MAX    = N_BASE + (1 << SEL_W) - 2;
  localparam int HALF_MAX = ((1 << N_MAX) + DIV_OFFSET) / 2;
  localparam int HALF_W   = $clog2(HALF_MAX + 1);
  localparam int PULSE_W  = $clog2(DATA_W + 2);

  sbus_cfg_t         cfg;
  logic [HALF_W-1:0] half_sel, half_q;
  logic              run, first, tick, scl_q, sda_q;

  sbus_cfg_reg u_reg (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .mon(bus_en), .cfg(cfg), .rdata(reg_rdata)
  );

  sbus_half_sel #(.N_BASE(N_BASE), .DIV_OFFSET(DIV_OFFSET), .HALF_W(HALF_W)) u_half (
    .sel(cfg.clksel), .half(half_sel)
  );

  sbus_phase_timer #(.HALF_W(HALF_W)) u_timer (
    .clk(clk), .rst(rst), .run(run), .half(half_q), .first(first), .tick(tick)
  );

  sbus_shift_core #(.DATA_W(DATA_W), .HALF_W(HALF_W), .PULSE_W(PULSE_W)) u_core (
    .clk(clk), .rst(rst), .en(bus_en), .tx_valid(tx_valid), .tx_data(tx_data),
    .cfg(cfg), .half_in(half_sel), .sda_in(sda_in), .first(first), .tick(tick),
    .tx_ready(tx_ready), .run(run), .half_q(half_q), .scl_q(scl_q), .sda_q(sda_q),
    .done(done), .ack_seen(ack_seen)
  );

  assign scl_oe = bus_en && !scl_q;
  assign sda_oe = bus_en && !sda_q;
endmodule

// File: rtl/sbus_shifter_chk.sv
module sbus_shifter_chk (
  input logic clk,
  input logic rst,
  input logic bus_en,
  input logic tx_valid,
  input logic tx_ready,
  input logic scl_oe,
  input logic sda_oe,
  input logic done
);
  // R6
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && $past(bus_en) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    scl_oe |-> !tx_ready);

  // R8
  accept_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (scl_oe || !bus_en));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_en |-> (!scl_oe && !sda_oe && !tx_ready));

  // R9
  abort_nodone_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_en) |-> !done);
endmodule

bind sbus_shifter sbus_shifter_chk u_chk (
  .clk(clk), .rst(rst), .bus_en(bus_en), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done)
);

// File: tb/sbus_shifter_tb.sv
module sbus_shifter_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_en = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       sda_in;
  logic       scl_oe, sda_oe, done, ack_seen;
  logic       slave_pull = 1'b0;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic exp_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_in = ~(sda_oe | slave_pull);

  sbus_shifter u_dut (
    .clk(clk), .rst(rst), .bus_en(bus_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .ack_seen(ack_seen)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic run_xfer(input logic [2:0] c, input logic a, input logic [2:0] s,
                          input logic [7:0] d, input logic pull, input bit midw);
    int nb, np, n, h, cyc, rn, rises, bad_w, bad_b, hi_chg, rdy_bad;
    logic prev_scl, prev_sda, scl, sdal;
    write_reg({1'b0, c, a, s});
    nb = (c == 3'd0) ? 8 : int'(c);
    np = nb + int'(a);
    n  = (s == 3'd7) ? 10 : int'(s) + 4;
    h  = ((1 << n) + 36) / 2;
    chk(tx_ready == 1'b1, "R8 ready idle", int'(tx_ready), 1);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
    cyc = 1; rn = 0; rises = 0; bad_w = 0; bad_b = 0; hi_chg = 0; rdy_bad = 0;
    prev_scl = 1'b1; prev_sda = sda_in;
    while (!done && cyc < 2*h*np + 10) begin
      scl = ~scl_oe; sdal = ~sda_oe;
      if (scl != prev_scl) begin
        if (cyc > 1 && rn != h) bad_w++;
        rn = 1;
        if (scl) begin
          if (rises < nb) begin
            if (sdal != d[7-rises]) bad_b++;
          end else if (sda_oe) bad_b++;
          rises++;
        end
      end else rn++;
      if (scl && prev_scl && sdal != prev_sda) hi_chg++;
      if (a && !scl && rises == nb) slave_pull = pull;
      if (tx_ready) rdy_bad++;
      if (midw && cyc == 3) begin reg_we = 1'b1; reg_wdata = {1'b0, c + 3'd3, ~a, 3'd6}; end
      if (midw && cyc == 4) reg_we = 1'b0;
      prev_scl = scl; prev_sda = sdal;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 2*h*np + 1, "R7 done cycle", cyc, 2*h*np + 1);
    chk(rises == np, "R3/R4 pulse count", rises, np);
    chk(bad_b == 0, "R3 data bits", bad_b, 0);
    chk(bad_w == 0 && rn == h, "R5 phase length", rn, h);
    chk(hi_chg == 0, "R6 sda high-phase change", hi_chg, 0);
    chk(rdy_bad == 0, "R8 ready while busy", rdy_bad, 0);
    if (midw) chk(rises == np && rn == h, "R10 config latched", rises, np);
    if (a) exp_ack = ~pull;
    @(negedge clk);
    slave_pull = 1'b0;
    chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
    chk(scl_oe == 1'b0, "R7 scl left high", int'(scl_oe), 0);
    chk(ack_seen == exp_ack, "R4 ack_seen", int'(ack_seen), int'(exp_ack));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    int nd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 8'h01, "R1 reset read", int'(reg_rdata), 1);
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released", int'(scl_oe), 0);
    chk(done == 0, "R7 done idle", int'(done), 0);
    chk(tx_ready == 1, "R8 ready after reset", int'(tx_ready), 1);

    write_reg(8'h5F);
    chk(reg_rdata == 8'h5F, "R1 field layout", int'(reg_rdata), 8'h5F);
    write_reg(8'h5E);
    chk(reg_rdata == 8'h5F, "R2 monitor overrides bit0", int'(reg_rdata), 8'h5F);
    bus_en = 1'b0;
    @(negedge clk);
    chk(reg_rdata == 8'h5E, "R2 monitor follows disable", int'(reg_rdata), 8'h5E);
    chk(tx_ready == 0, "R9 ready while disabled", int'(tx_ready), 0);
    bus_en = 1'b1;

    for (int c = 0; c < 8; c++)
      for (int a = 0; a < 2; a++)
        run_xfer(3'(c), 1'(a), 3'd0, 8'(8'hA5 ^ (c * 37 + a * 91)), 1'((c + a) % 2), 1'b0);

    for (int s = 0; s < 8; s++)
      run_xfer(3'd1, 1'b0, 3'(s), 8'h80 >> (s % 2), 1'b0, 1'b0);

    run_xfer(3'd2, 1'b1, 3'd1, 8'h6C, 1'b1, 1'b1);
    run_xfer(3'd0, 1'b0, 3'd0, 8'h3C, 1'b0, 1'b0);

    write_reg(8'h08);
    tx_valid = 1'b1; tx_data = 8'h00;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (40) @(negedge clk);
    bus_en = 1'b0;
    @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0, "R9 lines released", int'(scl_oe) + int'(sda_oe), 0);
    chk(tx_ready == 0, "R9 ready low", int'(tx_ready), 0);
    nd = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done || scl_oe || sda_oe) nd++;
    end
    chk(nd == 0, "R9 no done after abort", nd, 0);
    bus_en = 1'b1;
    @(negedge clk);
    chk(tx_ready == 1 && reg_rdata[0] == 1, "R9 recovery", int'(tx_ready), 1);
    run_xfer(3'd3, 1'b1, 3'd0, 8'hE0, 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule